// File: doc/BRIEF.md
# Asynchronous single-bit SRAM access sequencer

This block sits between a synchronous request interface and an external asynchronous static RAM of 16K one-bit words. The RAM has separate data-in and data-out pins. The block turns each accepted request into a chip-select and write-enable sequence that the RAM can use. Every interval is a whole number of clock cycles, and the integrator sets the counts from the clock period and the speed grade of the RAM.

The request side is a valid/ready stream. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so the requester must hold its request until it sees ready. While ready is low, the block ignores the request pins and their values have no effect. The response side does not push back. A read result arrives as a one-cycle `rd_valid` strobe, and `rd_data` holds that result until the next read completes.

Each access runs through four states: idle, setup, active and recover. In setup, the block drives the address and lowers chip select. In the active state, write enable is low for a write, or the block waits out the access time for a read. In recover, write enable is high and the address is still held. The block then returns to idle and raises chip select, so the RAM drops to standby between accesses.

Top module: `sram_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_cs_n` and `mem_we_n` are 1, `req_ready` is 1 and `rd_valid` is 0. Asserting reset in the middle of an access raises `mem_cs_n` and `mem_we_n` at once.
- R2: A request transfers when `req_valid` and `req_ready` are both high at a clock edge, and `req_ready` is 0 from the next cycle on. `req_ready` is high again exactly L+2 cycles after the transfer edge. L is the active length: max(T_WP, T_DW) for a write and T_AA for a read. Request pins presented while `req_ready` is 0 have no effect.
- R3: While `mem_we_n` is 0, `mem_cs_n` is 0 and `mem_addr` and `mem_din` do not change. `mem_cs_n` is already 0 in the cycle before `mem_we_n` falls.
- R4: Each write-enable pulse lasts exactly max(T_WP, T_DW) clock cycles. Write data is driven from the setup cycle on.
- R5: A read returns the bit last written to the same address.
- R6: For a read, `rd_valid` is 1 for exactly one cycle, T_AA+1 cycles after the transfer edge. A write never raises `rd_valid`.
- R7: Whenever `req_ready` is 1, `mem_cs_n` and `mem_we_n` are both 1, so the RAM is in standby between accesses.
- R8: A read never lowers `mem_we_n`. In the cycle after `mem_we_n` rises, `mem_cs_n` is still 0 and `mem_addr` is unchanged.
- R9: `rd_data` keeps its value until the next read completes. Writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; a request is taken this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (14) | Word address |
| req_wdata | input | 1 | Bit to write |
| rd_data | output | 1 | Last bit read |
| rd_valid | output | 1 | One-cycle strobe: `rd_data` updated |
| mem_addr | output | ADDR_W (14) | RAM address lines |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_din | output | 1 | RAM data input |
| mem_dout | input | 1 | RAM data output |

## Verification
A wrong sequencer state shows at the memory pins within one cycle. It appears as a write-enable pulse outside chip select, an address change under a low write enable, or chip select still low while ready is high. A counting fault in the cycle timer shows as a write pulse of the wrong length, or as a ready or `rd_valid` strobe that arrives a cycle early or late. A wrong capture point shows only when a read returns the wrong bit. For that reason the bench writes opposite values to neighbouring and extreme addresses before it reads them back.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_RECOVER = 2'd3
  } seq_state_e;

  function automatic int unsigned imax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] length,
  output logic             done
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (load)           remain <= length - 1'b1;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign done = (remain == '0);

  // R4: once expired the timer stays expired until reloaded
  p_timer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);
endmodule

// File: rtl/sram_seq_rdcap.sv
module sram_seq_rdcap (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic mem_dout,
  output logic rd_data,
  output logic rd_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= sample;
      if (sample) rd_data <= mem_dout;
    end
  end

  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample) |-> $stable(rd_data));
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int CNT_W   = 2,
  parameter int WR_LEN  = 2,
  parameter int RD_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  input  logic              tmr_done,
  output logic              req_ready,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_len,
  output logic              rd_sample,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_din
);
  seq_state_e state;
  logic       is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mem_cs_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_addr <= '0;
      mem_din  <= 1'b0;
      is_wr    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          state    <= ST_SETUP;
          mem_cs_n <= 1'b0;
          mem_addr <= req_addr;
          is_wr    <= req_we;
          if (req_we) mem_din <= req_wdata;
        end
        ST_SETUP: begin
          state    <= ST_ACTIVE;
          mem_we_n <= !is_wr;
        end
        ST_ACTIVE: if (tmr_done) begin
          state    <= ST_RECOVER;
          mem_we_n <= 1'b1;
        end
        default: begin
          state    <= ST_IDLE;
          mem_cs_n <= 1'b1;
        end
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign tmr_load  = (state == ST_SETUP);
  assign tmr_len   = is_wr ? CNT_W'(WR_LEN) : CNT_W'(RD_LEN);
  assign rd_sample = (state == ST_ACTIVE) && tmr_done && !is_wr;

  // pulse-width watcher for the checks below
  logic [CNT_W:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_run <= '0;
    else if (!mem_we_n) low_run <= low_run + 1'b1;
    else                low_run <= '0;
  end

  p_we_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_din)));
  p_cs_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_cs_n));
  p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (low_run == (CNT_W+1)'(WR_LEN)));
  p_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n));
  p_recover_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_cs_n && $stable(mem_addr)));
  p_busy_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !mem_cs_n) |=> $stable(mem_addr));
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int T_WP   = 2,
  parameter int T_DW   = 1,
  parameter int T_AA   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_din,
  input  logic              mem_dout
);
  localparam int WR_LEN  = int'(imax(T_WP, T_DW));
  localparam int LEN_MAX = int'(imax(WR_LEN, T_AA));
  localparam int CNT_W   = $clog2(LEN_MAX + 1);

  logic             tmr_load, tmr_done, rd_sample;
  logic [CNT_W-1:0] tmr_len;

  sram_seq_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WR_LEN(WR_LEN), .RD_LEN(T_AA)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .tmr_done(tmr_done),
    .req_ready(req_ready), .tmr_load(tmr_load), .tmr_len(tmr_len),
    .rd_sample(rd_sample),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_din(mem_din)
  );

  sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .length(tmr_len), .done(tmr_done)
  );

  sram_seq_rdcap u_rdcap (
    .clk(clk), .rst_n(rst_n), .sample(rd_sample), .mem_dout(mem_dout),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/sram_bit_model.sv
module sram_bit_model #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] a,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          din,
  output logic          dout
);
  logic [(1<<AW)-1:0] cells;

  always @(posedge we_n) if (cs_n === 1'b0) cells[a] <= din;
  always @(posedge cs_n) if (we_n === 1'b0) cells[a] <= din;

  assign dout = (!cs_n && we_n) ? cells[a] : 1'b0;
endmodule

// File: tb/test_sram_seq.sv
module test_sram_seq;
  localparam int AW = 14, T_WP = 2, T_DW = 1, T_AA = 2;
  localparam int PW = (T_WP > T_DW) ? T_WP : T_DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_wdata = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rd_data, rd_valid, mem_cs_n, mem_we_n, mem_din, mem_dout;
  logic [AW-1:0] mem_addr;

  int checks = 0, failures = 0;
  bit mon_en = 1'b0;
  logic [(1<<AW)-1:0] shadow = '0;
  logic last_rd = 1'b0;

  always #2 clk = ~clk;

  sram_seq #(.ADDR_W(AW), .T_WP(T_WP), .T_DW(T_DW), .T_AA(T_AA)) i_sram_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_din(mem_din),
    .mem_dout(mem_dout)
  );

  sram_bit_model #(.AW(AW)) u_ram (
    .a(mem_addr), .cs_n(mem_cs_n), .we_n(mem_we_n), .din(mem_din), .dout(mem_dout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // port monitor: R3, R4, R7, R8
  logic p_we_n = 1'b1, p_cs_n = 1'b1, p_din = 1'b0;
  logic [AW-1:0] p_addr = '0;
  int wl = 0;
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (!mem_we_n) begin
        check(!mem_cs_n, "R3 we low outside cs", mem_cs_n, 0);
        check(mem_addr == p_addr && mem_din == p_din, "R3 addr/din moved under we",
              int'(mem_addr), int'(p_addr));
        if (p_we_n) check(!p_cs_n, "R3 cs not ahead of we", p_cs_n, 0);
        wl++;
      end else if (!p_we_n) begin
        check(wl == PW, "R4 pulse width", wl, PW);
        check(!mem_cs_n && mem_addr == p_addr, "R8 recover hold", int'(mem_addr), int'(p_addr));
        wl = 0;
      end
      if (req_ready) check(mem_cs_n && mem_we_n, "R7 standby when ready",
                           int'({mem_cs_n, mem_we_n}), 3);
    end
    p_we_n = mem_we_n; p_cs_n = mem_cs_n; p_addr = mem_addr; p_din = mem_din;
  end

  task automatic access(input logic we, input logic [AW-1:0] a, input logic d);
    int cnt, seen, len;
    logic rv;
    len = we ? PW : T_AA;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R2 ready drops after transfer", req_ready, 0);
    cnt = 0; seen = -1; rv = 1'b0;
    while (!req_ready && cnt < 64) begin
      if (rd_valid) begin
        if (seen >= 0) check(0, "R6 rd_valid longer than one cycle", cnt, seen);
        seen = cnt; rv = rd_data;
      end
      @(negedge clk); cnt++;
    end
    check(cnt == len + 2, "R2 access length", cnt, len + 2);
    if (we) begin
      check(seen == -1, "R6 rd_valid on write", seen, -1);
      check(rd_data == last_rd, "R9 rd_data held across write", rd_data, last_rd);
      shadow[a] = d;
    end else begin
      check(seen == T_AA + 1, "R6 rd_valid timing", seen, T_AA + 1);
      check(rv == shadow[a], "R5 read data", rv, shadow[a]);
      last_rd = rv;
    end
  endtask

  // {we, data, addr}
  localparam logic [15:0] VEC [0:11] = '{
    {1'b1, 1'b1, 14'h0000}, {1'b1, 1'b0, 14'h3FFF}, {1'b1, 1'b1, 14'h2AAA},
    {1'b1, 1'b1, 14'h1555}, {1'b0, 1'b0, 14'h0000}, {1'b0, 1'b0, 14'h3FFF},
    {1'b0, 1'b0, 14'h2AAA}, {1'b1, 1'b0, 14'h0000}, {1'b0, 1'b0, 14'h0000},
    {1'b0, 1'b0, 14'h1555}, {1'b1, 1'b1, 14'h3FFF}, {1'b0, 1'b0, 14'h3FFF}
  };

  initial begin
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_we_n, "R1 reset pins", int'({mem_cs_n, mem_we_n}), 3);
    check(req_ready && !rd_valid, "R1 reset handshake", int'({req_ready, rd_valid}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_cs_n && mem_we_n && req_ready && !rd_valid, "R1 after reset",
          int'({mem_cs_n, mem_we_n, req_ready, rd_valid}), 14);
    mon_en = 1'b1;

    // clear the cells the bench reads before writing
    access(1'b1, 14'h1554, 1'b0);
    access(1'b1, 14'h0001, 1'b0);

    for (int i = 0; i < 12; i++)
      access(VEC[i][15], VEC[i][13:0], VEC[i][14]);

    // R2: request pins changed while busy have no effect
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 14'h0001; req_wdata = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    shadow[14'h0001] = 1'b1;
    req_addr = 14'h1554; req_wdata = 1'b1; req_we = 1'b1;
    for (int k = 0; k < PW + 1; k++) @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(req_ready, "R2 ready after busy window", req_ready, 1);
    access(1'b0, 14'h0001, 1'b0);
    access(1'b0, 14'h1554, 1'b0);

    // R1: reset during a write pulse
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 14'h0100; req_wdata = 1'b1;
    while (mem_we_n) @(negedge clk);
    req_valid = 1'b0; mon_en = 1'b0;
    #1 rst_n = 1'b0;
    #0.5;
    check(mem_cs_n && mem_we_n, "R1 async reset mid-access", int'({mem_cs_n, mem_we_n}), 3);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rd_valid, "R1 ready after reset", int'({req_ready, rd_valid}), 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule